// File: doc/BRIEF.md
# Dual Reference Frequency Tolerance Monitor

The block watches two reference clocks against a stable local clock and raises one out-of-tolerance flag for each reference. Each reference is brought into the local domain through a two-flop synchronizer. Its rising edges are detected and counted over a fixed gate of local clock cycles. Both channels share a single gate timer.

When a gate closes, each channel compares its count with a window of allowed counts around the nominal count. The window bounds are computed offline as the nominal count scaled by one minus and one plus 12 ppm, rounded outward. The result is registered and held until the next gate closes. Both references are monitored at all times, whichever one the surrounding logic has selected. The defaults describe a 100 MHz local clock, a 2 s gate and an 8.192 MHz reference. Simulation shortens the gate through the parameters.

Top module: `ppm_dual_ref_mon`

## Requirements
- R1: After reset both flags are 0, and they stay 0 until the first gate of GATE_CYCLES local cycles after reset release has completed.
- R2: A channel whose gate count lies within LO_COUNT..HI_COUNT inclusive reports flag 0.
- R3: A channel whose gate count is below LO_COUNT reports flag 1.
- R4: A channel whose gate count is above HI_COUNT reports flag 1.
- R5: A reference with no rising edges during a gate gives a count of zero, and its flag is 1.
- R6: A flag changes only on the clock edge that follows the last cycle of a gate. Two changes of a flag are therefore at least GATE_CYCLES cycles apart.
- R7: The two channels are independent. Bit 0 of alarm_o belongs to ref_i[0] and bit 1 to ref_i[1], and the count on one channel never affects the flag of the other.
- R8: A high level lasting at least one local cycle and preceded by at least one low cycle counts as exactly one edge, after a two-flop synchronizer.
- R9: The per-gate counter saturates instead of wrapping. A reference that is far too fast is never seen as in-window and always reports flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Stable local measurement clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 2 | Reference clocks, asynchronous to clk_i |
| alarm_o | output | 2 | Out-of-tolerance flag per reference, 1 = outside the window |

## Verification
The bench builds the block with GATE_CYCLES=240 and a window of 29..31 around a nominal count of 30. With these values a gate lasts only a few hundred cycles. The counter is 6 bits wide, so counts beyond 63 reach saturation. The bench drives each reference with a pattern that repeats every 240 cycles and contains exactly N single-cycle pulses. Because the pattern repeats with the gate length, every gate sees exactly N edges whatever its phase. This allows the bench to sweep every count from 0 to 60 on one channel while the mirrored count runs on the other. It also applies counts of 64 and 120, which lie past the saturation point.

// File: rtl/ppm_mon_pkg.sv
package ppm_mon_pkg;
  localparam int unsigned NUM_REF   = 2;
  localparam int unsigned SYNC_STGS = 2;

  function automatic int unsigned cnt_width(input int unsigned hi_count);
    return $clog2(hi_count + 2);
  endfunction
endpackage

// File: rtl/ppm_ref_sync.sv
module ppm_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], ref_i};
  end

  // rising edge on the last synchronized stage
  assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  a_r8_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/ppm_gate_timer.sv
module ppm_gate_timer #(
  parameter int unsigned GATE_CYCLES = 200_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic gate_end_o
);
  localparam int unsigned TW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           tmr_q <= '0;
    else if (tmr_q == LAST) tmr_q <= '0;
    else                   tmr_q <= tmr_q + 1'b1;
  end

  assign gate_end_o = (tmr_q == LAST);

  a_r6_timer_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= LAST);
  a_r6_gate_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_end_o |=> (tmr_q == '0));
endmodule

// File: rtl/ppm_edge_counter.sv
module ppm_edge_counter #(
  parameter int unsigned LO_COUNT = 16_383_803,
  parameter int unsigned HI_COUNT = 16_384_197
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic gate_end_i,
  output logic flag_o
);
  import ppm_mon_pkg::*;
  localparam int unsigned CW = cnt_width(HI_COUNT);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] LO_C = CW'(LO_COUNT);
  localparam logic [CW-1:0] HI_C = CW'(HI_COUNT);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          flag_q, out_win;

  // saturate so a runaway reference cannot alias into the window
  assign cnt_nx  = (cnt_q == CMAX) ? CMAX : cnt_q + CW'(edge_i);
  assign out_win = (cnt_nx < LO_C) || (cnt_nx > HI_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (gate_end_i) begin
      cnt_q  <= '0;
      flag_q <= out_win;
    end else begin
      cnt_q  <= cnt_nx;
    end
  end

  assign flag_o = flag_q;

  a_r6_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_end_i |=> $stable(flag_q));
  a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_end_i |=> (cnt_q >= $past(cnt_q)));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_end_i |=> (cnt_q == '0));
endmodule

// File: rtl/ppm_dual_ref_mon.sv
module ppm_dual_ref_mon #(
  parameter int unsigned GATE_CYCLES = 200_000_000,
  parameter int unsigned NOM_COUNT   = 16_384_000,
  parameter int unsigned LO_COUNT    = 16_383_803,
  parameter int unsigned HI_COUNT    = 16_384_197
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ref_i,
  output logic [1:0] alarm_o
);
  import ppm_mon_pkg::*;

  logic                gate_end;
  logic [NUM_REF-1:0]  edge_det;
  logic [NUM_REF-1:0]  flag;

  ppm_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gate_end_o(gate_end)
  );

  for (genvar i = 0; i < NUM_REF; i++) begin : g_ch
    ppm_ref_sync #(.STAGES(SYNC_STGS)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ref_i (ref_i[i]),
      .edge_o(edge_det[i])
    );
    ppm_edge_counter #(.LO_COUNT(LO_COUNT), .HI_COUNT(HI_COUNT)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .edge_i    (edge_det[i]),
      .gate_end_i(gate_end),
      .flag_o    (flag[i])
    );
  end

  assign alarm_o = flag;

  initial begin
    a_r2_window_order: assert (LO_COUNT <= NOM_COUNT && NOM_COUNT <= HI_COUNT);
  end

  a_r1_rise_at_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o != $past(alarm_o)) |-> $past(gate_end));
endmodule

// File: tb/sim_ppm_dual_ref_mon.sv
module sim_ppm_dual_ref_mon;
  localparam int G   = 240;
  localparam int NOM = 30;
  localparam int LO  = 29;
  localparam int HI  = 31;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ref_s = 2'b00;
  logic [1:0] alarm;

  int n0 = 0, n1 = 0;
  int pos = 0;
  int cyc = 0;
  int vecs = 0, errs = 0;
  bit done = 0;
  int last_chg [2];
  logic [1:0] prev_alarm = 2'b00;
  bit mon_on = 0;

  always #2 clk = ~clk;

  ppm_dual_ref_mon #(.GATE_CYCLES(G), .NOM_COUNT(NOM), .LO_COUNT(LO), .HI_COUNT(HI)) u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .ref_i  (ref_s),
    .alarm_o(alarm)
  );

  // pattern with exactly n pulses in every G-cycle span
  always @(negedge clk) begin
    cyc <= cyc + 1;
    pos <= (pos + 1) % G;
    ref_s[0] <= ((pos * n0) % G) < n0;
    ref_s[1] <= ((pos * n1) % G) < n1;
  end

  // R6: two changes of one flag must lie at least G cycles apart
  always @(negedge clk) begin
    if (mon_on) begin
      for (int b = 0; b < 2; b++) begin
        if (alarm[b] !== prev_alarm[b]) begin
          vecs++;
          if (cyc - last_chg[b] < G) begin
            errs++;
            $display("FAIL R6 ch%0d change gap actual=%0d expected>=%0d", b, cyc - last_chg[b], G);
          end
          last_chg[b] = cyc;
        end
      end
    end
    prev_alarm <= alarm;
  end

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%b expected=%b (n0=%0d n1=%0d)", req, act, exp, n0, n1);
    end
  endtask

  function automatic logic bad(input int n);
    return (n < LO) || (n > HI);
  endfunction

  task automatic step(input int a, input int b, input string req);
    logic [1:0] exp, first;
    n0 = a; n1 = b;
    repeat (2 * G + 10) @(negedge clk);
    exp = {bad(b), bad(a)};
    first = alarm;
    for (int k = 0; k < G; k++) begin
      @(negedge clk);
      if (alarm !== first) begin
        errs++; vecs++;
        $display("FAIL R6 flag moved in steady state actual=%b expected=%b", alarm, first);
        break;
      end
    end
    check(req, alarm, exp);
  endtask

  initial begin
    last_chg[0] = -G; last_chg[1] = -G;
    repeat (3) @(negedge clk);
    check("R1 reset", alarm, 2'b00);
    rst_n = 1'b1;
    repeat (G - 6) @(negedge clk);
    check("R1 before first gate", alarm, 2'b00);
    mon_on = 1;
    repeat (G + 10) @(negedge clk);
    check("R5 no edges", alarm, 2'b11);
    for (int n = 0; n <= 60; n++) begin
      if (n >= LO && n <= HI) step(n, 60 - n, "R2/R7 in window");
      else if (n < LO)        step(n, 60 - n, "R3/R7 low count");
      else                    step(n, 60 - n, "R4/R7 high count");
    end
    step(NOM, 0, "R5 R7 silent ch1");
    step(LO, HI, "R2 R8 bounds");
    step(LO - 1, HI + 1, "R3 R4 just outside");
    step(120, 64, "R9 saturation");
    step(NOM, 120, "R9 R7 mixed");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150_000) @(negedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule